// File: doc/BRIEF.md
# Sharing-Aware Shared Victim Cache

This block is a last-level cache shared by four cores that holds only lines pushed out of the cores' private second-level caches. A lookup that misses never causes a fill from below; lines enter only through the victim-insert port. Each lookup is marked as either an instruction fetch or a data load. A hit returns the 64-bit line one cycle after the request is granted.

What happens to the line after a hit depends on two things: the kind of request, and a per-line record of whether more than one core has used it. Instruction fetches always leave the line resident. A data load leaves it resident only when the line has a sharing history, and otherwise the line is invalidated after it is returned. Each line records the last core that touched it. A touch from any other core marks the line as shared.

Lookups from the four cores are arbitrated round-robin, one per cycle. A victim insert takes the cycle ahead of any lookup. Each of the four sets holds 32 ways, and when a set is full the least recently used way is replaced.

Top module: `svc_cache`

## Requirements
- R1: After reset every way is invalid and every sharing bit is clear, so any lookup misses, and `rsp_valid` is low until the first granted lookup.
- R2: An inserted victim is found by a later lookup of the same address, which returns the inserted data. A lookup miss never allocates a line. The low 2 address bits select the set and the upper `TAG_W` bits form the tag.
- R3: At most one core is granted per cycle, and only a core whose `req_valid` bit is set. The search starts at the core after the last one served and wraps around. The first grant after reset starts the search at core 0. `req_grant` is one-hot, with bit i meaning core i.
- R4: In a cycle where `ins_valid` is high, no lookup is granted.
- R5: The cycle after a grant, `rsp_valid` is high, `rsp_core` names the granted core, and `rsp_hit` and `rsp_data` give the outcome. In any cycle without a grant, `rsp_valid` is low in the following cycle.
- R6: On a miss, `rsp_hit` is 0, `rsp_data` is 0, and the cache contents do not change.
- R7: An instruction-fetch hit (`req_ifetch` bit set) leaves the line valid, whichever core asks.
- R8: A data-load hit leaves the line valid only if the line's sharing bit is already set, or if the requesting core differs from the core recorded as the last toucher. Otherwise the line is invalidated. On any retained hit, the recorded core becomes the requester and the sharing bit takes the updated value.
- R9: Inserting into a set that holds 32 valid lines evicts the least recently used line. Both inserts and hits count as uses. Sets do not affect each other.
- R10: Inserting an address already present overwrites that way's data and makes it the most recently used, without using a second way. If the inserting core differs from the recorded core, the sharing bit is set, and the inserting core becomes the recorded core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Victim insert this cycle |
| ins_addr | input | TAG_W+2 | Victim line address (tag, set) |
| ins_data | input | DATA_W | Victim line data |
| ins_core | input | 2 | Core that evicted the victim |
| req_valid | input | 4 | Per-core lookup request |
| req_ifetch | input | 4 | Per-core request type: 1 fetch, 0 data load |
| req_addr | input | 4*(TAG_W+2) | Per-core lookup address, core i in slice i |
| req_grant | output | 4 | One-hot grant of this cycle's lookup |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_core | output | 2 | Core the response belongs to |
| rsp_data | output | DATA_W | Line data on a hit, zero on a miss |

## Verification
The two functions that can fall in the same cycle are the victim insert and the lookup arbitration. The bench provokes this by raising `ins_valid` while all four cores hold requests. It then checks that the grant is empty and that no response follows, and that the next cycle's grant resumes from the core after the last one served. A second collision happens in state, where an insert lands on a tag that a lookup just retained or dropped. A behavioural queue model, kept in recency order, predicts the grant, hit, data and retention on every clock, through long random mixes over a small tag space.

// File: rtl/svc_cache.sv
module svc_cache #(
  parameter int TAG_W  = 12,
  parameter int DATA_W = 64,
  parameter int WAYS   = 32,
  parameter int SETS   = 4,
  parameter int NCORE  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_valid,
  input  logic [TAG_W+$clog2(SETS)-1:0] ins_addr,
  input  logic [DATA_W-1:0]         ins_data,
  input  logic [$clog2(NCORE)-1:0]  ins_core,
  input  logic [NCORE-1:0]          req_valid,
  input  logic [NCORE-1:0]          req_ifetch,
  input  logic [NCORE*(TAG_W+$clog2(SETS))-1:0] req_addr,
  output logic [NCORE-1:0]          req_grant,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [$clog2(NCORE)-1:0]  rsp_core,
  output logic [DATA_W-1:0]         rsp_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int CID_W  = $clog2(NCORE);
  localparam int ADDR_W = TAG_W + IDX_W;

  logic              vld_q [SETS][WAYS];
  logic              shr_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [CID_W-1:0]  own_q [SETS][WAYS];
  logic [WAY_W-1:0]  age_q [SETS][WAYS];
  logic [CID_W-1:0]  rr_last;

  logic              gnt_any;
  logic [CID_W-1:0]  gnt_id;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_set;
  logic [TAG_W-1:0]  op_tag;
  logic              hit, have_free;
  logic [WAY_W-1:0]  hit_way, free_way, old_way, tw;
  logic              touch, shared_now, keep;

  always_comb begin
    gnt_any = 1'b0;
    gnt_id  = '0;
    if (!ins_valid)
      for (int k = 1; k <= NCORE; k++)
        if (!gnt_any && req_valid[rr_last + CID_W'(k)]) begin
          gnt_any = 1'b1;
          gnt_id  = rr_last + CID_W'(k);
        end
  end

  assign req_grant = gnt_any ? (NCORE'(1) << gnt_id) : '0;
  assign op_addr   = ins_valid ? ins_addr : req_addr[gnt_id*ADDR_W +: ADDR_W];
  assign op_set    = op_addr[IDX_W-1:0];
  assign op_tag    = op_addr[ADDR_W-1:IDX_W];

  always_comb begin
    hit = 1'b0; hit_way = '0;
    have_free = 1'b0; free_way = '0;
    old_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && vld_q[op_set][w] && tag_q[op_set][w] == op_tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!have_free && !vld_q[op_set][w]) begin
        have_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (age_q[op_set][w] == WAY_W'(WAYS-1))
        old_way = WAY_W'(w);
    end
  end

  assign tw         = hit ? hit_way : (have_free ? free_way : old_way);
  assign touch      = ins_valid | (gnt_any & hit);
  assign shared_now = shr_q[op_set][hit_way] | (own_q[op_set][hit_way] != gnt_id);
  assign keep       = req_ifetch[gnt_id] | shared_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_core  <= '0;
      rsp_data  <= '0;
      rr_last   <= CID_W'(NCORE-1);
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          shr_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          dat_q[s][w] <= '0;
          own_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      rsp_valid <= gnt_any;
      rsp_hit   <= gnt_any & hit;
      rsp_core  <= gnt_id;
      rsp_data  <= (gnt_any && hit) ? dat_q[op_set][hit_way] : '0;
      if (gnt_any) rr_last <= gnt_id;
      if (touch)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == tw)
            age_q[op_set][w] <= '0;
          else if (age_q[op_set][w] < age_q[op_set][tw])
            age_q[op_set][w] <= age_q[op_set][w] + 1'b1;
        end
      if (ins_valid) begin
        vld_q[op_set][tw] <= 1'b1;
        tag_q[op_set][tw] <= op_tag;
        dat_q[op_set][tw] <= ins_data;
        own_q[op_set][tw] <= ins_core;
        shr_q[op_set][tw] <= hit ? (shr_q[op_set][tw] | (own_q[op_set][tw] != ins_core)) : 1'b0;
      end else if (gnt_any && hit) begin
        own_q[op_set][tw] <= gnt_id;
        shr_q[op_set][tw] <= shared_now;
        if (!keep) vld_q[op_set][tw] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/svc_cache_chk.sv
module svc_cache_chk #(
  parameter int NCORE  = 4,
  parameter int DATA_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic [NCORE-1:0] req_valid,
  input logic [NCORE-1:0] req_grant,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [DATA_W-1:0] rsp_data
);
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));
  assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);
  assert_insert_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> req_grant == '0);
  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_grant) |=> rsp_valid);
  assert_no_rsp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_grant) |=> !rsp_valid);
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_data == '0);
  assert_hit_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

bind svc_cache svc_cache_chk #(.NCORE(NCORE), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .req_valid(req_valid),
  .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
);

// File: tb/svc_cache_test.sv
module svc_cache_test;
  localparam int TW = 12;
  localparam int AW = TW + 2;

  typedef struct { logic [TW-1:0] tag; logic [63:0] data; int owner; bit shared; } ent_t;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0;
  logic [AW-1:0] ins_addr = 0;
  logic [63:0] ins_data = 0;
  logic [1:0] ins_core = 0;
  logic [3:0] req_valid = 0, req_ifetch = 0;
  logic [4*AW-1:0] req_addr = 0;
  logic [3:0] req_grant;
  logic rsp_valid, rsp_hit;
  logic [1:0] rsp_core;
  logic [63:0] rsp_data;

  int tests = 0, fails = 0;
  ent_t q[4][$];
  int rr = 3;
  bit d_iv; logic [AW-1:0] d_ia; logic [63:0] d_id; int d_ic;
  logic [3:0] d_rv, d_rf; logic [AW-1:0] d_ra [4];

  always #4 clk = ~clk;

  svc_cache uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_data(ins_data), .ins_core(ins_core), .req_valid(req_valid),
    .req_ifetch(req_ifetch), .req_addr(req_addr), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_core(rsp_core), .rsp_data(rsp_data)
  );

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int find(int s, logic [TW-1:0] t);
    for (int i = 0; i < q[s].size(); i++) if (q[s][i].tag == t) return i;
    return -1;
  endfunction

  task automatic step(string ph);
    int gi, s, idx;
    logic [3:0] eg;
    bit ev, eh; logic [63:0] ed;
    ent_t e;
    logic [TW-1:0] t;
    ins_valid = d_iv; ins_addr = d_ia; ins_data = d_id; ins_core = 2'(d_ic);
    req_valid = d_rv; req_ifetch = d_rf;
    req_addr = {d_ra[3], d_ra[2], d_ra[1], d_ra[0]};
    #1;
    gi = -1; eg = 0;
    if (!d_iv) for (int k = 1; k <= 4; k++) if (gi < 0 && d_rv[(rr + k) % 4]) gi = (rr + k) % 4;
    if (gi >= 0) eg[gi] = 1'b1;
    chk(req_grant == eg, d_iv ? "R4 grant" : "R3 grant", 64'(req_grant), 64'(eg));
    ev = gi >= 0; eh = 0; ed = 0;
    if (d_iv) begin
      s = d_ia[1:0]; t = d_ia[AW-1:2]; idx = find(s, t);
      if (idx >= 0) begin
        e = q[s][idx]; q[s].delete(idx);
        e.shared = e.shared || (e.owner != d_ic); e.owner = d_ic; e.data = d_id;
      end else begin
        if (q[s].size() == 32) void'(q[s].pop_back());
        e.tag = t; e.data = d_id; e.owner = d_ic; e.shared = 0;
      end
      q[s].push_front(e);
    end else if (gi >= 0) begin
      rr = gi;
      s = d_ra[gi][1:0]; t = d_ra[gi][AW-1:2]; idx = find(s, t);
      if (idx >= 0) begin
        bit sh;
        e = q[s][idx]; eh = 1; ed = e.data;
        sh = e.shared || (e.owner != gi);
        q[s].delete(idx);
        if (d_rf[gi] || sh) begin
          e.shared = sh; e.owner = gi; q[s].push_front(e);
        end
      end
    end
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == ev, "R5 valid", 64'(rsp_valid), 64'(ev));
    if (ev) begin
      chk(rsp_core == 2'(gi), "R5 core", 64'(rsp_core), 64'(gi));
      chk(rsp_hit == eh, eh ? ph : {"R6 ", ph}, 64'(rsp_hit), 64'(eh));
      chk(rsp_data == ed, eh ? ph : {"R6 ", ph}, rsp_data, ed);
    end
  endtask

  task automatic idle();
    d_iv = 0; d_rv = 0; d_rf = 0;
  endtask

  task automatic ins(int tag, int set, logic [63:0] data, int core, string ph);
    idle(); d_iv = 1; d_ia = {TW'(tag), 2'(set)}; d_id = data; d_ic = core;
    step(ph);
  endtask

  task automatic look(int core, int tag, int set, bit ifetch, string ph);
    idle(); d_rv[core] = 1; d_rf[core] = ifetch; d_ra[core] = {TW'(tag), 2'(set)};
    step(ph);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) d_ra[i] = 0;
    idle(); d_ia = 0; d_id = 0; d_ic = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1 reset valid", 64'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 idle after reset", 64'(rsp_valid), 0);

    look(0, 5, 0, 1, "R1 empty lookup");
    for (int c = 0; c < 4; c++) look(c, c + 7, c, 0, "R1 empty lookup");

    idle(); d_rv = 4'hF;
    for (int i = 0; i < 4; i++) d_ra[i] = AW'(i * 9);
    for (int n = 0; n < 9; n++) step("R3 rotation");
    d_rv = 4'b1010;
    for (int n = 0; n < 4; n++) step("R3 sparse rotation");

    ins(10, 1, 64'hA5A5_0000_1111_2222, 0, "R2 insert");
    look(0, 10, 1, 1, "R2 hit after insert");
    look(3, 10, 1, 1, "R7 fetch keeps");
    look(3, 10, 1, 1, "R7 fetch keeps");
    look(1, 11, 1, 0, "R2 no fill on miss");
    look(1, 11, 1, 0, "R2 no fill on miss");

    ins(20, 1, 64'h2020_2020_0000_0001, 2, "R8 insert");
    look(2, 20, 1, 0, "R8 same core load");
    look(2, 20, 1, 0, "R8 dropped after load");
    ins(21, 1, 64'h2121_0000_0000_0002, 1, "R8 insert");
    look(3, 21, 1, 0, "R8 other core load");
    look(3, 21, 1, 0, "R8 shared kept");
    look(3, 21, 1, 0, "R8 shared kept");

    ins(30, 3, 64'h0000_0000_0000_0030, 0, "R10 first");
    ins(30, 3, 64'hFFFF_0000_0000_0031, 0, "R10 overwrite");
    look(0, 30, 3, 0, "R10 new data");
    look(0, 30, 3, 0, "R10 single way");
    ins(31, 3, 64'h3131, 0, "R10 first");
    ins(31, 3, 64'h3132, 1, "R10 other core");
    look(1, 31, 3, 0, "R10 shared by insert");
    look(1, 31, 3, 0, "R10 shared by insert");

    idle(); d_rv = 4'hF; d_iv = 1; d_ia = {TW'(40), 2'd0}; d_id = 64'h40; d_ic = 2;
    for (int i = 0; i < 4; i++) d_ra[i] = {TW'(40), 2'd0};
    step("R4 collide");
    d_iv = 0;
    step("R4 resume");
    step("R4 resume");

    for (int t = 100; t < 132; t++) ins(t, 2, 64'(t) << 8, t % 4, "R9 fill");
    look(0, 100, 2, 1, "R9 refresh");
    ins(132, 2, 64'h132, 0, "R9 evict");
    look(0, 101, 2, 1, "R9 lru evicted");
    look(0, 100, 2, 1, "R9 refreshed kept");
    look(0, 132, 2, 1, "R9 new kept");
    look(2, 10, 1, 1, "R9 other set intact");

    for (int n = 0; n < 4000; n++) begin
      idle();
      d_iv = ($urandom_range(0, 3) == 0);
      d_ia = {TW'($urandom_range(0, 40)), 2'($urandom_range(0, 3))};
      d_id = {$urandom, $urandom};
      d_ic = $urandom_range(0, 3);
      d_rv = 4'($urandom);
      d_rf = 4'($urandom);
      for (int i = 0; i < 4; i++) d_ra[i] = {TW'($urandom_range(0, 40)), 2'($urandom_range(0, 3))};
      step("R8 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule